// File: doc/BRIEF.md
# Receive Descriptor Writeback Engine

This engine walks a list of four-word receive descriptors kept in memory for a packet receive path. It fetches a descriptor and checks that the DMA owns it. It then presents the two buffer addresses and their sizes to the data mover. When that mover reports a finished segment, the engine returns status and ownership to software. Descriptors are linked in one of two ways, chosen per descriptor. In ring mode they sit back to back at 16-byte steps and wrap to the list base after a configured count. In chained mode the fourth word points at the next descriptor.

The fourth word serves two purposes. Before completion it holds the second buffer pointer or the next-descriptor pointer. At completion of the last segment of a frame, when timestamping is on, the engine overwrites the third and fourth words with a 64-bit capture time. Both of these writes reach memory before the word that releases ownership. If a fetched descriptor is still owned by software, the engine parks in a suspended state. It fetches that descriptor again only after a poll-demand pulse.

Top module: `rx_desc_engine`

## Requirements
- R1: After reset the engine issues no memory request and shows neither `desc_ready` nor `suspended` until `start` is pulsed.
- R2: A `start` pulse in the idle state reads word 0 at `cfg_base`. If bit 31 (ownership) of that word is 1, the engine reads words 1 to 3 and raises `desc_ready`. It then presents word 2 as `buf1_addr`, word 1 bits [12:0] as `buf1_size` and word 1 bits [28:16] as `buf2_size`.
- R3: A fetched word 0 with bit 31 at 0 raises `suspended`. The engine then issues no memory request until `poll_demand`, after which it reads the same descriptor again.
- R4: When word 1 bit 24 (chained) is 1, the next descriptor address is word 3 with bits [1:0] cleared, and `buf2_addr` is 0.
- R5: When the chained bit is 0, `buf2_addr` is the full word 3 if the descriptor begins a frame. Otherwise it is word 3 with bits [1:0] cleared. A descriptor begins a frame if it is the first after `start`, or if the previous completed segment had its last flag set.
- R6: When the chained bit is 0, the next descriptor sits at the current address plus 16. After `cfg_ring_cnt` descriptors taken this way, it wraps back to `cfg_base`.
- R7: With `cfg_ts_en` at 1 and a segment whose last flag is set, the engine writes `ts_in[31:0]` to word 2 and `ts_in[63:32]` to word 3. Both values are sampled with `seg_valid`. Both writes complete before the word 0 write.
- R8: With `cfg_ts_en` at 0, or a segment without the last flag, words 2 and 3 are not written, and word 0 is the only write for that descriptor.
- R9: The word 0 writeback is a single write with this layout: bit 31 = 0, bit 9 = first flag, bit 8 = last flag, bits [29:16] = frame length so far, all other bits 0. The frame length so far is the segment length when the first flag is set, and otherwise the previous frame length plus the segment length.
- R10: Each memory request keeps its address, direction and data stable until `mem_ack`, and every address has bits [1:0] at 0.
- R11: `seg_valid` is ignored unless `desc_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | 32 | Word-aligned list base address |
| cfg_ring_cnt | input | 8 | Descriptors in the ring before wrap |
| cfg_ts_en | input | 1 | Enable timestamp writeback |
| start | input | 1 | Begin walking at the base (idle only) |
| poll_demand | input | 1 | Retry after suspension |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| desc_ready | output | 1 | Owned descriptor held, awaiting a segment |
| desc_addr | output | 32 | Address of the current descriptor |
| buf1_addr | output | 32 | First buffer address |
| buf1_size | output | 13 | First buffer size |
| buf2_addr | output | 32 | Second buffer address (0 when chained) |
| buf2_size | output | 13 | Second buffer size |
| seg_valid | input | 1 | Segment complete pulse |
| seg_first | input | 1 | Segment opens a frame |
| seg_last | input | 1 | Segment closes a frame |
| seg_len | input | 14 | Segment byte count |
| ts_in | input | 64 | Capture timestamp |
| suspended | output | 1 | Stopped on a software-owned descriptor |

## Verification
The embedded assertions check on every cycle:
- Requests hold steady until acknowledged and stay word aligned.
- A suspended engine stays off the bus.
- No word 0 write sets the ownership bit.
- No word 0 write happens while a timestamp write is still owed.
- The ring index stays inside the configured count.

Several behaviours only the directed scenarios can show, because they depend on memory contents across descriptors:
- The values of the buffer addresses under first-of-frame and mid-frame masking.
- The next-descriptor choice and ring wrap.
- The accumulated frame length.
- The exact set and order of writes.

// File: rtl/rxd_pkg.sv
package rxd_pkg;
  localparam int DATA_W   = 32;
  localparam int LEN_W    = 14;
  localparam int SIZE_W   = 13;
  localparam int DESC_B   = 16;
  localparam int OWN_BIT  = 31;
  localparam int CHN_BIT  = 24;

  typedef enum logic [3:0] {
    ST_IDLE, ST_RD0, ST_RD1, ST_RD2, ST_RD3,
    ST_SUSP, ST_READY, ST_WR2, ST_WR3, ST_WR0
  } eng_state_t;

  function automatic logic [31:0] f_clr_low(input logic [31:0] a);
    return {a[31:2], 2'b00};
  endfunction

  function automatic logic [31:0] f_buf2(input logic [31:0] w3,
                                         input logic chained,
                                         input logic frame_start);
    if (chained)          return 32'h0;
    else if (frame_start) return w3;
    else                  return f_clr_low(w3);
  endfunction

  function automatic logic [31:0] f_status(input logic [LEN_W-1:0] len,
                                           input logic first,
                                           input logic last);
    return {2'b00, len, 6'b000000, first, last, 8'h00};
  endfunction

  function automatic logic [LEN_W-1:0] f_frame_len(input logic first,
                                                   input logic [LEN_W-1:0] acc,
                                                   input logic [LEN_W-1:0] seg);
    return first ? seg : acc + seg;
  endfunction
endpackage

// File: rtl/rxd_link.sv
module rxd_link
  import rxd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic [31:0]      cur_addr,
  input  logic [31:0]      base,
  input  logic [CNT_W-1:0] idx,
  input  logic [CNT_W-1:0] ring_cnt,
  input  logic             chained,
  input  logic [31:0]      w3,
  input  logic             frame_start,
  output logic [31:0]      next_addr,
  output logic [CNT_W-1:0] next_idx,
  output logic [31:0]      buf2_addr
);
  logic [CNT_W:0] idx_inc;
  logic           ring_wrap;

  assign idx_inc   = {1'b0, idx} + 1'b1;
  assign ring_wrap = idx_inc >= {1'b0, ring_cnt};

  always_comb begin
    if (chained) begin
      next_addr = f_clr_low(w3);
      next_idx  = idx;
    end else if (ring_wrap) begin
      next_addr = base;
      next_idx  = '0;
    end else begin
      next_addr = cur_addr + DESC_B;
      next_idx  = idx_inc[CNT_W-1:0];
    end
  end

  assign buf2_addr = f_buf2(w3, chained, frame_start);
endmodule

// File: rtl/rxd_frame_track.sv
module rxd_frame_track
  import rxd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             commit,
  input  logic             seg_first,
  input  logic             seg_last,
  input  logic [LEN_W-1:0] seg_len,
  output logic             frame_start,
  output logic [LEN_W-1:0] len_total
);
  logic [LEN_W-1:0] acc_q;

  assign len_total = f_frame_len(seg_first, acc_q, seg_len);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q       <= '0;
      frame_start <= 1'b1;
    end else if (restart) begin
      acc_q       <= '0;
      frame_start <= 1'b1;
    end else if (commit) begin
      acc_q       <= seg_last ? '0 : len_total;
      frame_start <= seg_last;
    end
  end
endmodule

// File: rtl/rx_desc_engine.sv
module rx_desc_engine
  import rxd_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       cfg_base,
  input  logic [CNT_W-1:0]  cfg_ring_cnt,
  input  logic              cfg_ts_en,
  input  logic              start,
  input  logic              poll_demand,
  output logic              mem_req,
  output logic              mem_we,
  output logic [31:0]       mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic [31:0]       mem_rdata,
  input  logic              mem_ack,
  output logic              desc_ready,
  output logic [31:0]       desc_addr,
  output logic [31:0]       buf1_addr,
  output logic [SIZE_W-1:0] buf1_size,
  output logic [31:0]       buf2_addr,
  output logic [SIZE_W-1:0] buf2_size,
  input  logic              seg_valid,
  input  logic              seg_first,
  input  logic              seg_last,
  input  logic [LEN_W-1:0]  seg_len,
  input  logic [63:0]       ts_in,
  output logic              suspended
);
  eng_state_t        state;
  logic [31:0]       cur_q, w2_q, w3_q;
  logic [CNT_W-1:0]  idx_q, next_idx;
  logic [SIZE_W-1:0] sz1_q, sz2_q;
  logic              chn_q;
  logic              cap_first, cap_last, ts_pend;
  logic [LEN_W-1:0]  cap_len, len_total;
  logic [63:0]       cap_ts;
  logic [31:0]       next_addr;
  logic              frame_start;
  logic [1:0]        word_sel;

  // named events for the assertions
  logic restart_ev, commit_ev, seg_take_ev, w0_write_ev;
  assign restart_ev  = (state == ST_IDLE) && start;
  assign commit_ev   = (state == ST_WR0) && mem_ack;
  assign seg_take_ev = (state == ST_READY) && seg_valid;
  assign w0_write_ev = mem_req && mem_we && (word_sel == 2'd0);

  rxd_link #(.CNT_W(CNT_W)) u_link (
    .cur_addr   (cur_q),
    .base       (cfg_base),
    .idx        (idx_q),
    .ring_cnt   (cfg_ring_cnt),
    .chained    (chn_q),
    .w3         (w3_q),
    .frame_start(frame_start),
    .next_addr  (next_addr),
    .next_idx   (next_idx),
    .buf2_addr  (buf2_addr)
  );

  rxd_frame_track u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .restart    (restart_ev),
    .commit     (commit_ev),
    .seg_first  (cap_first),
    .seg_last   (cap_last),
    .seg_len    (cap_len),
    .frame_start(frame_start),
    .len_total  (len_total)
  );

  always_comb begin
    mem_req  = 1'b0;
    mem_we   = 1'b0;
    word_sel = 2'd0;
    mem_wdata = 32'h0;
    case (state)
      ST_RD0: begin mem_req = 1'b1; word_sel = 2'd0; end
      ST_RD1: begin mem_req = 1'b1; word_sel = 2'd1; end
      ST_RD2: begin mem_req = 1'b1; word_sel = 2'd2; end
      ST_RD3: begin mem_req = 1'b1; word_sel = 2'd3; end
      ST_WR2: begin mem_req = 1'b1; mem_we = 1'b1; word_sel = 2'd2;
                    mem_wdata = cap_ts[31:0]; end
      ST_WR3: begin mem_req = 1'b1; mem_we = 1'b1; word_sel = 2'd3;
                    mem_wdata = cap_ts[63:32]; end
      ST_WR0: begin mem_req = 1'b1; mem_we = 1'b1; word_sel = 2'd0;
                    mem_wdata = f_status(len_total, cap_first, cap_last); end
      default: ;
    endcase
  end

  assign mem_addr   = cur_q + {28'h0, word_sel, 2'b00};
  assign desc_ready = (state == ST_READY);
  assign suspended  = (state == ST_SUSP);
  assign desc_addr  = cur_q;
  assign buf1_addr  = w2_q;
  assign buf1_size  = sz1_q;
  assign buf2_size  = sz2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cur_q     <= '0;
      idx_q     <= '0;
      w2_q      <= '0;
      w3_q      <= '0;
      sz1_q     <= '0;
      sz2_q     <= '0;
      chn_q     <= 1'b0;
      cap_first <= 1'b0;
      cap_last  <= 1'b0;
      cap_len   <= '0;
      cap_ts    <= '0;
      ts_pend   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (start) begin
          cur_q <= cfg_base;
          idx_q <= '0;
          state <= ST_RD0;
        end
        ST_RD0: if (mem_ack) state <= mem_rdata[OWN_BIT] ? ST_RD1 : ST_SUSP;
        ST_SUSP: if (poll_demand) state <= ST_RD0;
        ST_RD1: if (mem_ack) begin
          sz1_q <= mem_rdata[12:0];
          sz2_q <= mem_rdata[28:16];
          chn_q <= mem_rdata[CHN_BIT];
          state <= ST_RD2;
        end
        ST_RD2: if (mem_ack) begin
          w2_q  <= mem_rdata;
          state <= ST_RD3;
        end
        ST_RD3: if (mem_ack) begin
          w3_q  <= mem_rdata;
          state <= ST_READY;
        end
        ST_READY: if (seg_valid) begin
          cap_first <= seg_first;
          cap_last  <= seg_last;
          cap_len   <= seg_len;
          cap_ts    <= ts_in;
          ts_pend   <= cfg_ts_en && seg_last;
          state     <= (cfg_ts_en && seg_last) ? ST_WR2 : ST_WR0;
        end
        ST_WR2: if (mem_ack) state <= ST_WR3;
        ST_WR3: if (mem_ack) begin
          ts_pend <= 1'b0;
          state   <= ST_WR0;
        end
        ST_WR0: if (mem_ack) begin
          cur_q <= next_addr;
          idx_q <= next_idx;
          state <= ST_RD0;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R10: request held until acknowledged
  assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_wdata)));
  // R10: word-aligned accesses
  assert_addr_align_R10: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00));
  // R3: no bus traffic while suspended
  assert_quiet_susp_R3: assert property (@(posedge clk) disable iff (!rst_n)
    suspended |-> !mem_req);
  // R9: ownership always released by the status write
  assert_own_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    w0_write_ev |-> !mem_wdata[OWN_BIT]);
  // R7: timestamp words land before the ownership release
  assert_ts_first_R7: assert property (@(posedge clk) disable iff (!rst_n)
    w0_write_ev |-> !ts_pend);
  // R7: a timestamped segment starts with the word 2 write
  assert_ts_order_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (seg_take_ev && cfg_ts_en && seg_last) |=> (mem_we && word_sel == 2'd2));
  // R6: ring index stays inside the configured count
  assert_idx_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_ring_cnt != '0) |-> (idx_q < cfg_ring_cnt));
  // R1: idle engine stays off the bus
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_IDLE) |-> (!mem_req && !desc_ready && !suspended));
endmodule

// File: tb/test_rx_desc_engine.sv
module test_rx_desc_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cfg_base = 32'h40;
  logic [7:0]  cfg_ring_cnt = 8'd3;
  logic        cfg_ts_en = 1'b1;
  logic        start = 1'b0, poll_demand = 1'b0;
  logic        mem_req, mem_we, mem_ack = 1'b0;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = 32'h0;
  logic        desc_ready, suspended;
  logic [31:0] desc_addr, buf1_addr, buf2_addr;
  logic [12:0] buf1_size, buf2_size;
  logic        seg_valid = 1'b0, seg_first = 1'b0, seg_last = 1'b0;
  logic [13:0] seg_len = '0;
  logic [63:0] ts_in = '0;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] mem [0:63];
  logic [31:0] log_a [0:15];
  logic [31:0] log_d [0:15];
  int log_n = 0;

  always #10 clk = ~clk;

  rx_desc_engine i_rx_desc_engine (
    .clk(clk), .rst_n(rst_n), .cfg_base(cfg_base), .cfg_ring_cnt(cfg_ring_cnt),
    .cfg_ts_en(cfg_ts_en), .start(start), .poll_demand(poll_demand),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack), .desc_ready(desc_ready),
    .desc_addr(desc_addr), .buf1_addr(buf1_addr), .buf1_size(buf1_size),
    .buf2_addr(buf2_addr), .buf2_size(buf2_size), .seg_valid(seg_valid),
    .seg_first(seg_first), .seg_last(seg_last), .seg_len(seg_len), .ts_in(ts_in),
    .suspended(suspended));

  // memory responder: one access every two cycles, serviced away from the edge
  always @(negedge clk) begin
    if (mem_ack) mem_ack = 1'b0;
    else if (mem_req && rst_n) begin
      if (mem_we) begin
        mem[mem_addr[7:2]] = mem_wdata;
        if (log_n < 16) begin
          log_a[log_n] = mem_addr;
          log_d[log_n] = mem_wdata;
        end
        log_n = log_n + 1;
      end else mem_rdata = mem[mem_addr[7:2]];
      mem_ack = 1'b1;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_ready(input string req);
    int n = 0;
    while (!desc_ready && n < 400) begin @(negedge clk); n++; end
    chk(req, {31'h0, desc_ready}, 32'h1);
  endtask

  task automatic wait_susp(input string req);
    int n = 0;
    while (!suspended && n < 400) begin @(negedge clk); n++; end
    chk(req, {31'h0, suspended}, 32'h1);
  endtask

  task automatic send_seg(input logic f, input logic l, input logic [13:0] len,
                          input logic [63:0] ts);
    log_n = 0;
    @(negedge clk);
    seg_valid = 1'b1; seg_first = f; seg_last = l; seg_len = len; ts_in = ts;
    @(negedge clk);
    seg_valid = 1'b0; ts_in = '0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    chk("R1 req", {31'h0, mem_req}, 32'h0);
    chk("R1 ready", {31'h0, desc_ready}, 32'h0);
    chk("R1 susp", {31'h0, suspended}, 32'h0);
  endtask

  task automatic t_ring_frame;
    @(negedge clk); start = 1'b1; @(negedge clk); start = 1'b0;
    wait_ready("R2 first fetch");
    chk("R2 addr", desc_addr, 32'h40);
    chk("R2 buf1", buf1_addr, 32'h1000);
    chk("R2 size1", {19'h0, buf1_size}, 32'd100);
    chk("R2 size2", {19'h0, buf2_size}, 32'd200);
    chk("R5 start full", buf2_addr, 32'h2003);
    // seg_valid while waiting is the only one taken; R8 no timestamp on non-last
    send_seg(1'b1, 1'b0, 14'd300, 64'hAAAA_BBBB_CCCC_DDDD);
    wait_ready("R6 step");
    chk("R6 next", desc_addr, 32'h50);
    chk("R8 one write", log_n, 32'd1);
    chk("R9 status0", log_d[0], 32'h012C_0200);
    chk("R8 w2 kept", mem[6'h12], 32'h1000);
    chk("R8 w3 kept", mem[6'h13], 32'h2003);
    chk("R5 middle mask", buf2_addr, 32'h3004);
    send_seg(1'b0, 1'b1, 14'd50, 64'h1122_3344_5566_7788);
    wait_ready("R6 step2");
    chk("R6 next2", desc_addr, 32'h60);
    chk("R7 three writes", log_n, 32'd3);
    chk("R7 order a0", log_a[0], 32'h58);
    chk("R7 ts low", log_d[0], 32'h5566_7788);
    chk("R7 order a1", log_a[1], 32'h5C);
    chk("R7 ts high", log_d[1], 32'h1122_3344);
    chk("R7 order a2", log_a[2], 32'h50);
    chk("R9 accum", log_d[2], 32'h015E_0100);
    chk("R5 new frame", buf2_addr, 32'h5001);
  endtask

  task automatic t_ts_off_and_wrap;
    cfg_ts_en = 1'b0;
    send_seg(1'b1, 1'b1, 14'd64, 64'hFFFF_EEEE_DDDD_CCCC);
    wait_susp("R3 wrap suspend");
    chk("R6 wrap", desc_addr, 32'h40);
    chk("R8 ts off", log_n, 32'd1);
    chk("R9 single", log_d[0], 32'h0040_0300);
    chk("R8 w3 kept", mem[6'h1B], 32'h5001);
  endtask

  task automatic t_suspend_poll;
    int busy = 0;
    log_n = 0;
    repeat (20) begin
      @(negedge clk);
      if (mem_req) busy++;
      seg_valid = 1'b1; seg_first = 1'b1; seg_last = 1'b1; seg_len = 14'd9;
    end
    seg_valid = 1'b0;
    chk("R3 quiet", busy, 32'd0);
    chk("R11 ignored", log_n, 32'd0);
    chk("R11 still susp", {31'h0, suspended}, 32'h1);
    // hand a chained descriptor back to the engine
    mem[6'h10] = 32'h8000_0000;
    mem[6'h11] = 32'h0100_0010;
    mem[6'h12] = 32'h4000;
    mem[6'h13] = 32'h0000_0073;
    cfg_ts_en = 1'b1;
    @(negedge clk); poll_demand = 1'b1; @(negedge clk); poll_demand = 1'b0;
    wait_ready("R3 refetch");
    chk("R3 same addr", desc_addr, 32'h40);
    chk("R4 buf2 zero", buf2_addr, 32'h0);
    chk("R4 buf1", buf1_addr, 32'h4000);
    send_seg(1'b1, 1'b1, 14'd10, 64'h0000_0007_0000_0009);
    wait_susp("R4 chained suspend");
    chk("R4 next masked", desc_addr, 32'h70);
    chk("R9 chained status", mem[6'h10], 32'h000A_0300);
    chk("R7 chained ts", mem[6'h13], 32'h7);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) mem[i] = 32'h0;
    mem[6'h10] = 32'h8000_0000; mem[6'h11] = 32'h00C8_0064;
    mem[6'h12] = 32'h1000;      mem[6'h13] = 32'h2003;
    mem[6'h14] = 32'h8000_0000; mem[6'h15] = 32'h0010_0020;
    mem[6'h16] = 32'h1100;      mem[6'h17] = 32'h3007;
    mem[6'h18] = 32'h8000_0000; mem[6'h19] = 32'h0010_0020;
    mem[6'h1A] = 32'h1200;      mem[6'h1B] = 32'h5001;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_ring_frame();
    t_ts_off_and_wrap();
    t_suspend_poll();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= 20000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 20000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule